// File: doc/BRIEF.md
# Frame Interrupt Spacing Monitor

This block checks that a periodic frame interrupt arrives at the expected spacing. It uses a free-running timer clocked from the same master clock as the interrupt source. A prescaler divides the master clock into timer ticks. The ticks drive a down-counter that reloads itself and covers several frame periods. On each rising edge of the interrupt, the monitor samples the counter and subtracts that sample from the previous one. If the counter reloaded between the two samples, the subtraction is corrected for the wrap.

The monitor compares the tick difference with a nominal frame length plus or minus a jitter allowance. When the difference falls outside that window, it raises a one-cycle lost-frame flag. The measured difference stays on an output until the next interrupt, so surrounding logic can log it or act on it.

Top module: `frame_gap_monitor`

## Requirements
- R1: A timer tick occurs once every PRESCALE master clocks. Each tick lowers the counter by one, so the interval reported between two interrupts that lie k*PRESCALE clocks apart counts k ticks, taken modulo the counter span.
- R2: The counter span is SPAN = FRAME_TICKS*FRAMES_PER_SPAN ticks. After reaching zero, the counter reloads SPAN-1 on the next tick.
- R3: An interrupt is taken on the rising edge of frame_irq_i. A level held high for several clocks counts as one interrupt.
- R4: diff_o equals the previous sample minus the new sample. When the previous sample is smaller than the new one, SPAN is added first, so diff_o always lies in 0..SPAN-1.
- R5: lost_o fires when diff_o < FRAME_TICKS-JITTER or diff_o > FRAME_TICKS+JITTER. Both window edges count as good.
- R6: The first interrupt after reset only stores a sample. lost_o stays low and diff_o keeps 0.
- R7: lost_o is high for exactly the one clock that follows the interrupt edge. diff_o updates on that same clock and holds its value until the next interrupt.
- R8: While reset is active, and right after it, lost_o is 0 and diff_o is 0.
- R9: The sample taken at each interrupt becomes the reference for the next one, so consecutive intervals are measured back to back with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_irq_i | input | 1 | Frame interrupt; its rising edge triggers a measurement |
| lost_o | output | 1 | One-cycle pulse when the measured spacing is outside the window |
| diff_o | output | DIFF_W | Ticks measured between the last two interrupts |

## Verification
The bench builds the monitor with PRESCALE=2, FRAME_TICKS=20, FRAMES_PER_SPAN=4 and JITTER=1. The span is therefore 80 ticks and diff_o is 8 bits wide. With these values the bench can make dozens of counter reloads within a few thousand clocks. It can also reach both edges of the jitter window and intervals of exactly one span (reported as 0). Intervals longer than one span alias back into range. Because intervals are whole multiples of the prescale, the expected difference does not depend on the prescaler phase.

// File: rtl/fgm_pkg.sv
package fgm_pkg;
  // true when a measured gap lies outside nominal +/- jitter
  function automatic logic gap_outside(int unsigned gap, int unsigned nominal,
                                       int unsigned jitter);
    return ((gap + jitter) < nominal) || (gap > (nominal + jitter));
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned PRESCALE = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (PRESCALE <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] div_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
      end

      assign tick_o = (div_q == LAST);

      AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R1
    end
  endgenerate
endmodule

// File: rtl/reload_counter.sv
module reload_counter #(
  parameter int unsigned SPAN  = 7500,
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SPAN - 1);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              count_q <= RELOAD;
    else if (tick_i) begin
      if (count_q == '0)      count_q <= RELOAD;
      else                    count_q <= count_q - 1'b1;
    end
  end

  assign count_o = count_q;

  AST_COUNT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= RELOAD); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_q)); // R1
  AST_COUNT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_q == '0) |=> count_q == RELOAD); // R2
endmodule

// File: rtl/gap_checker.sv
module gap_checker
  import fgm_pkg::*;
#(
  parameter int unsigned SPAN        = 7500,
  parameter int unsigned CNT_W       = 13,
  parameter int unsigned DIFF_W      = 14,
  parameter int unsigned FRAME_TICKS = 1875,
  parameter int unsigned JITTER      = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              lost_o,
  output logic [DIFF_W-1:0] diff_o
);
  localparam logic [DIFF_W-1:0] SPAN_D = DIFF_W'(SPAN);

  logic [CNT_W-1:0]  prev_q;
  logic              armed_q;
  logic              lost_q;
  logic [DIFF_W-1:0] diff_q, diff_d;

  // down-counter: elapsed = prev - now, unwrapped by one span
  always_comb begin
    diff_d = {1'b0, prev_q} - {1'b0, count_i};
    if (prev_q < count_i) diff_d = diff_d + SPAN_D;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
      lost_q  <= 1'b0;
      diff_q  <= '0;
    end else begin
      lost_q <= 1'b0;
      if (sample_i) begin
        prev_q  <= count_i;
        armed_q <= 1'b1;
        if (armed_q) begin
          diff_q <= diff_d;
          lost_q <= gap_outside(32'(diff_d), FRAME_TICKS, JITTER);
        end
      end
    end
  end

  assign lost_o = lost_q;
  assign diff_o = diff_q;

  AST_LOST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_q |=> !lost_q); // R7
  AST_LOST_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !armed_q) |=> !lost_q); // R6
  AST_DIFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(diff_q)); // R7
  AST_DIFF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diff_q < SPAN_D); // R4
endmodule

// File: rtl/frame_gap_monitor.sv
module frame_gap_monitor #(
  parameter  int unsigned PRESCALE        = 12,
  parameter  int unsigned FRAME_TICKS     = 1875,
  parameter  int unsigned FRAMES_PER_SPAN = 4,
  parameter  int unsigned JITTER          = 1,
  localparam int unsigned SPAN            = FRAME_TICKS * FRAMES_PER_SPAN,
  localparam int unsigned CNT_W           = $clog2(SPAN),
  localparam int unsigned DIFF_W          = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_irq_i,
  output logic              lost_o,
  output logic [DIFF_W-1:0] diff_o
);
  logic             tick;
  logic [CNT_W-1:0] count;
  logic             irq_q;
  logic             sample;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= frame_irq_i;
  end

  assign sample = frame_irq_i & ~irq_q;

  AST_SAMPLE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample |=> !sample); // R3

  tick_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  reload_counter #(.SPAN(SPAN), .CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .count_o (count)
  );

  gap_checker #(
    .SPAN(SPAN), .CNT_W(CNT_W), .DIFF_W(DIFF_W),
    .FRAME_TICKS(FRAME_TICKS), .JITTER(JITTER)
  ) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .count_i  (count),
    .lost_o   (lost_o),
    .diff_o   (diff_o)
  );
endmodule

// File: tb/sim_frame_gap_monitor.sv
module sim_frame_gap_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int P   = 2;
  localparam int FT  = 20;
  localparam int FPS = 4;
  localparam int JIT = 1;
  localparam int DW  = $clog2(FT * FPS) + 1;
  localparam int NV  = 12;

  // interval in ticks, expected diff, expected lost
  localparam int VEC_TICKS [NV] = '{20, 19, 21, 18, 22, 40, 80, 100, 5, 99, 101, 159};
  localparam int VEC_DIFF  [NV] = '{20, 19, 21, 18, 22, 40,  0,  20, 5, 19,  21,  79};
  localparam int VEC_LOST  [NV] = '{ 0,  0,  0,  1,  1,  1,  1,   0, 1,  0,   0,   1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq = 1'b0;
  logic lost;
  logic [DW-1:0] diff;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_gap_monitor #(.PRESCALE(P), .FRAME_TICKS(FT), .FRAMES_PER_SPAN(FPS), .JITTER(JIT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_irq_i(irq), .lost_o(lost), .diff_o(diff)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // at a negedge: raise irq for hold clocks; returns clocks consumed
  task automatic fire(input int hold, input int exp_diff, input int exp_lost,
                      input string tag, output int used);
    irq = 1'b1;
    @(negedge clk);
    check({tag, " R4 diff"}, int'(diff), exp_diff);
    check({tag, " R5 lost"}, int'(lost), exp_lost);
    for (int i = 1; i < hold; i++) begin
      @(negedge clk);
      check({tag, " R3 held level no relost"}, int'(lost), 0);
    end
    irq = 1'b0;
    @(negedge clk);
    check({tag, " R7 pulse end"}, int'(lost), 0);
    check({tag, " R7 diff held"}, int'(diff), exp_diff);
    used = hold + 1;
  endtask

  task automatic wait_rest(input int ticks, input int used);
    repeat (ticks * P - used) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int used;
    repeat (3) @(negedge clk);
    check("R8 reset lost", int'(lost), 0);
    check("R8 reset diff", int'(diff), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 after reset lost", int'(lost), 0);
    check("R8 after reset diff", int'(diff), 0);

    // R6: first interrupt stores only
    fire(1, 0, 0, "R6 first", used);
    wait_rest(VEC_TICKS[0], used);

    // R1 R2 R9: back-to-back intervals, crossing many reloads
    for (int v = 0; v < NV; v++) begin
      fire(1, VEC_DIFF[v], VEC_LOST[v], $sformatf("R9 vec%0d", v), used);
      if (v + 1 < NV) wait_rest(VEC_TICKS[v + 1], used);
      else            wait_rest(21, used);
    end
    // last wait was 21 ticks; R3: long level counts once
    fire(6, 21, 0, "R3 long", used);
    wait_rest(20, used);
    fire(1, 20, 0, "R3 after long", used);

    // R5 window edges with jitter 1: 19 and 21 good, 23 bad
    wait_rest(23, used);
    fire(1, 23, 1, "R5 above", used);

    // mid-run reset: R8 then R6 again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 mid reset lost", int'(lost), 0);
    check("R8 mid reset diff", int'(diff), 0);
    rst_n = 1'b1;
    repeat (7) @(negedge clk);
    fire(1, 0, 0, "R6 rearm", used);
    wait_rest(30, used);
    fire(1, 30, 1, "R9 after rearm", used);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule